// File: doc/BRIEF.md
# GPIO Interrupt Slot Array

The block offers a fixed set of interrupt slots (32 by default). Each slot routes one chosen GPIO interrupt line to one level request towards a parent interrupt controller. Software sets a slot up through a simple register port: a select byte gives the slot's enable bit and a 7-bit source number, and a 2-bit sense field picks one of four detection types: rising edge, falling edge, level high or level low. Each slot latches what it sees into a status bit. Software clears that bit by writing zero to it. The slot's request is high while the slot is enabled and its status bit is set.

Each slot runs a small state machine with three states. `SLOT_OFF` means the slot is disabled and does no detection. `SLOT_SETTLE` is a one-cycle window after any change to the slot's configuration; in it the new source is sampled but no edge is judged. `SLOT_ARMED` means edges are detected against the previous sample of the same source. The transitions are as follows. Any write that alters the slot's select byte or sense field moves the slot to `SLOT_SETTLE` from every state. `SLOT_OFF` moves to `SLOT_SETTLE` when it is enabled. `SLOT_SETTLE` moves to `SLOT_ARMED` when it is enabled, and to `SLOT_OFF` otherwise. `SLOT_ARMED` stays where it is while enabled and drops to `SLOT_OFF` otherwise.

Register reads are registered: `rd_data` shows the value addressed in a cycle with `rd_en` high from the following cycle on.

Top module: `gpio_irq_slot_array`

## Requirements
- R1: After reset every register (status 0x20, sense 0x24/0x28, select 0x30..0x4C) reads zero and all `slot_req` bits are low.
- R2: Slot k is configured in the select register at offset 0x30 + 4*(k/4), in bits [8*(k%4)+7 : 8*(k%4)]. Bit 7 of that byte is the enable and bits 6:0 are the source number. The value written reads back unchanged.
- R3: Sense register 0x24 serves slots 0-15 and 0x28 serves slots 16-31. The field of slot k is bits [2m+1:2m] with m = k%16. The value written reads back unchanged.
- R4: Sense code 0 (rising edge): when the selected input goes from 0 to 1 on an armed slot, the status bit is set at that clock edge. It then stays set until it is cleared, whatever the input does afterwards.
- R5: Sense code 1 (falling edge): a 1-to-0 change of the selected input on an armed slot sets the status bit, and the bit stays set.
- R6: Sense code 2 (level high): at every clock edge the status bit takes the value of the enabled slot's input.
- R7: Sense code 3 (level low): at every clock edge the status bit takes the inverse of the enabled slot's input.
- R8: A write to 0x20 clears each status bit written as 0 and leaves each bit written as 1 untouched. An edge event in the same cycle wins over the clear.
- R9: A slot whose enable bit is 0 never sets its status bit and keeps its request low.
- R10: A source number at or above the number of GPIO inputs behaves as a constant low input.
- R11: A write that changes a slot's enable, source or sense starts one settling cycle. An edge is only judged from the second clock edge after the write, so the change alone never creates an event.
- R12: In the level modes a clear write has no lasting effect; the status bit keeps following the qualified level.
- R13: Each `slot_req` bit is active high and equals the slot's enable ANDed with its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| gpio_irq | input | NUM_SRC | GPIO interrupt lines, synchronous to `clk` |
| slot_req | output | NUM_SLOTS | Level interrupt request for each slot |

## Verification
The bench goes after the settling window. It moves a slot from a low source to a high one, enables a slot while its input is already high, and flips a slot's sense from rising to falling. A design that compared the old source's sample with the new one, or that skipped the settling cycle, would raise a request with no real edge. It also checks that a clear in a level mode is undone at once while the input stays active, that an edge landing in the same cycle as a clear survives, and that a source number past the last input behaves as a low input. A design that indexed past the input vector, or that let a clear win, would give a wrong status bit or a wrong request.

// File: rtl/gpio_slot_pkg.sv
package gpio_slot_pkg;

    localparam int SRC_W      = 7;
    localparam int SRC_SPAN   = 1 << SRC_W;
    localparam int STATUS_OFS = 'h20;
    localparam int SENSE_OFS  = 'h24;
    localparam int SELECT_OFS = 'h30;

    typedef enum logic [1:0] {
        SENSE_RISE = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_HIGH = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

    typedef enum logic [1:0] {
        SLOT_OFF    = 2'd0,
        SLOT_SETTLE = 2'd1,
        SLOT_ARMED  = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } slot_cfg_t;

endpackage

// File: rtl/gpio_slot_cfg_regs.sv
module gpio_slot_cfg_regs
    import gpio_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wr_data,
    input  logic [NUM_SLOTS-1:0]        status_i,
    output slot_cfg_t [NUM_SLOTS-1:0]   cfg_o,
    output logic [NUM_SLOTS-1:0][1:0]   sense_o,
    output logic [NUM_SLOTS-1:0]        chg_o,
    output logic [NUM_SLOTS-1:0]        clr_o,
    output logic [31:0]                 rd_data
);

    localparam int SLOTS_PER_SEL   = 4;
    localparam int SLOTS_PER_SENSE = 16;

    logic status_hit;
    assign status_hit = wr_en && (addr == ADDR_W'(STATUS_OFS));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        localparam int SEL_ADR = SELECT_OFS + 4 * (k / SLOTS_PER_SEL);
        localparam int SEL_LSB = 8 * (k % SLOTS_PER_SEL);
        localparam int SNS_ADR = SENSE_OFS + 4 * (k / SLOTS_PER_SENSE);
        localparam int SNS_LSB = 2 * (k % SLOTS_PER_SENSE);

        slot_cfg_t  cfg_q;
        logic [1:0] sns_q;
        logic       sel_hit;
        logic       sns_hit;
        slot_cfg_t  cfg_new;
        logic [1:0] sns_new;

        assign sel_hit = wr_en && (addr == ADDR_W'(SEL_ADR));
        assign sns_hit = wr_en && (addr == ADDR_W'(SNS_ADR));
        assign cfg_new = wr_data[SEL_LSB +: 8];
        assign sns_new = wr_data[SNS_LSB +: 2];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '0;
                sns_q <= '0;
            end else begin
                if (sel_hit) cfg_q <= cfg_new;
                if (sns_hit) sns_q <= sns_new;
            end
        end

        assign chg_o[k]   = (sel_hit && (cfg_new != cfg_q)) ||
                            (sns_hit && (sns_new != sns_q));
        assign clr_o[k]   = status_hit && !wr_data[k];
        assign cfg_o[k]   = cfg_q;
        assign sense_o[k] = sns_q;
    end

    logic [31:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (addr == ADDR_W'(STATUS_OFS)) begin
            rd_next[NUM_SLOTS-1:0] = status_i;
        end
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (addr == ADDR_W'(SELECT_OFS + 4 * (k / SLOTS_PER_SEL))) begin
                rd_next[8 * (k % SLOTS_PER_SEL) +: 8] = cfg_o[k];
            end
            if (addr == ADDR_W'(SENSE_OFS + 4 * (k / SLOTS_PER_SENSE))) begin
                rd_next[2 * (k % SLOTS_PER_SENSE) +: 2] = sense_o[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> (cfg_o == '0));

endmodule

// File: rtl/gpio_irq_slot.sv
module gpio_irq_slot
    import gpio_slot_pkg::*;
#(
    parameter int NUM_SRC = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] gpio_i,
    input  slot_cfg_t          cfg_i,
    input  logic [1:0]         sense_i,
    input  logic               chg_i,
    input  logic               clr_i,
    output logic               status_o,
    output logic               req_o
);

    logic [SRC_SPAN-1:0] padded;

    if (NUM_SRC >= SRC_SPAN) begin : g_full
        assign padded = gpio_i[SRC_SPAN-1:0];
    end else begin : g_pad
        assign padded = {{(SRC_SPAN - NUM_SRC){1'b0}}, gpio_i};
    end

    sense_e      mode;
    slot_state_e state_q;
    slot_state_e state_d;
    logic        smp;
    logic        prev_q;
    logic        status_q;
    logic        is_level;
    logic        edge_evt;
    logic        level_val;

    assign mode     = sense_e'(sense_i);
    assign smp      = padded[cfg_i.src];
    assign is_level = sense_i[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (chg_i) begin
            state_d = SLOT_SETTLE;
        end else begin
            unique case (state_q)
                SLOT_OFF:    state_d = cfg_i.en ? SLOT_SETTLE : SLOT_OFF;
                SLOT_SETTLE: state_d = cfg_i.en ? SLOT_ARMED  : SLOT_OFF;
                SLOT_ARMED:  state_d = cfg_i.en ? SLOT_ARMED  : SLOT_OFF;
                default:     state_d = SLOT_OFF;
            endcase
        end
    end

    always_comb begin
        edge_evt  = 1'b0;
        level_val = 1'b0;
        unique case (mode)
            SENSE_RISE: edge_evt  = (state_q == SLOT_ARMED) && cfg_i.en && smp && !prev_q;
            SENSE_FALL: edge_evt  = (state_q == SLOT_ARMED) && cfg_i.en && !smp && prev_q;
            SENSE_HIGH: level_val = cfg_i.en && smp;
            SENSE_LOW:  level_val = cfg_i.en && !smp;
            default:    edge_evt  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            prev_q   <= 1'b0;
        end else begin
            prev_q <= smp;
            if (is_level) begin
                status_q <= level_val;
            end else if (edge_evt) begin
                status_q <= 1'b1;
            end else if (clr_i) begin
                status_q <= 1'b0;
            end
        end
    end

    assign status_o = status_q;
    assign req_o    = cfg_i.en && status_q;

    // R4
    sticky_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level && status_q && !clr_i && !chg_i) |=> status_q);

    // R8
    clear_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level && clr_i && !edge_evt && !chg_i) |=> !status_q);

    // R6
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_HIGH && cfg_i.en && smp && !chg_i) |=> status_q);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.en && !status_q && !chg_i) |=> !status_q);

    // R11
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SLOT_ARMED && !is_level && !status_q && !chg_i) |=> !status_q);

    // R11
    settle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (state_q == SLOT_SETTLE));

endmodule

// File: rtl/gpio_irq_slot_array.sv
module gpio_irq_slot_array
    import gpio_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_SRC   = 128,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    input  logic [NUM_SRC-1:0]   gpio_irq,
    output logic [NUM_SLOTS-1:0] slot_req
);

    slot_cfg_t [NUM_SLOTS-1:0]  cfg;
    logic [NUM_SLOTS-1:0][1:0]  sense;
    logic [NUM_SLOTS-1:0]       chg;
    logic [NUM_SLOTS-1:0]       clr;
    logic [NUM_SLOTS-1:0]       status;

    gpio_slot_cfg_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .status_i (status),
        .cfg_o    (cfg),
        .sense_o  (sense),
        .chg_o    (chg),
        .clr_o    (clr),
        .rd_data  (rd_data)
    );

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        gpio_irq_slot #(
            .NUM_SRC (NUM_SRC)
        ) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .gpio_i   (gpio_irq),
            .cfg_i    (cfg[k]),
            .sense_i  (sense[k]),
            .chg_i    (chg[k]),
            .clr_i    (clr[k]),
            .status_o (status[k]),
            .req_o    (slot_req[k])
        );
    end

    // R13
    req_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_req & ~status) == '0));

endmodule

// File: tb/gpio_irq_slot_array_tb.sv
module gpio_irq_slot_array_tb_top;

    localparam int NS   = 32;
    localparam int NSRC = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NSRC-1:0] gpio = '0;
    logic [NS-1:0] slot_req;

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";

    gpio_irq_slot_array #(.NUM_SLOTS(NS), .NUM_SRC(NSRC), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .gpio_irq(gpio), .slot_req(slot_req)
    );

    always #10 clk = ~clk;

    // behavioural reference
    bit         m_en   [NS];
    logic [6:0] m_src  [NS];
    logic [1:0] m_sns  [NS];
    bit         m_stat [NS];
    bit         m_prev [NS];
    int         m_st   [NS];
    logic [31:0] m_rd;
    bit          rd_chk;

    function automatic logic [31:0] mread(logic [7:0] a);
        logic [31:0] r = '0;
        for (int k = 0; k < NS; k++) begin
            if (a == 8'h20) r[k] = m_stat[k];
            if (a == 8'(8'h24 + 4 * (k / 16))) r[2*(k%16) +: 2] = m_sns[k];
            if (a == 8'(8'h30 + 4 * (k / 4))) r[8*(k%4) +: 8] = {m_en[k], m_src[k]};
        end
        return r;
    endfunction

    function automatic logic [NS-1:0] mreq();
        logic [NS-1:0] r;
        for (int k = 0; k < NS; k++) r[k] = m_en[k] & m_stat[k];
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) begin
                m_en[k] = 0; m_src[k] = '0; m_sns[k] = '0;
                m_stat[k] = 0; m_prev[k] = 0; m_st[k] = 0;
            end
            rd_chk = 0;
            m_rd = '0;
        end else begin
            bit         chg [NS];
            bit         s, ev, clr;
            logic [7:0] nb;
            if (rd_en) begin
                m_rd = mread(addr);
                rd_chk = 1;
            end
            for (int k = 0; k < NS; k++) begin
                s = (int'(m_src[k]) < NSRC) ? gpio[m_src[k]] : 1'b0;
                chg[k] = 0;
                if (wr_en && addr == 8'(8'h30 + 4 * (k / 4))) begin
                    nb = wr_data[8*(k%4) +: 8];
                    if (nb != {m_en[k], m_src[k]}) chg[k] = 1;
                end
                if (wr_en && addr == 8'(8'h24 + 4 * (k / 16)))
                    if (wr_data[2*(k%16) +: 2] != m_sns[k]) chg[k] = 1;
                clr = wr_en && addr == 8'h20 && !wr_data[k];
                if (m_sns[k] >= 2) begin
                    m_stat[k] = m_en[k] && ((m_sns[k] == 2) ? s : !s);
                end else begin
                    ev = (m_st[k] == 2) && m_en[k] &&
                         ((m_sns[k] == 0) ? (s && !m_prev[k]) : (!s && m_prev[k]));
                    if (ev) m_stat[k] = 1;
                    else if (clr) m_stat[k] = 0;
                end
                m_prev[k] = s;
                if (chg[k]) m_st[k] = 1;
                else if (m_st[k] == 0) m_st[k] = m_en[k] ? 1 : 0;
                else m_st[k] = m_en[k] ? 2 : 0;
            end
            for (int k = 0; k < NS; k++) begin
                if (wr_en && addr == 8'(8'h30 + 4 * (k / 4)))
                    {m_en[k], m_src[k]} = wr_data[8*(k%4) +: 8];
                if (wr_en && addr == 8'(8'h24 + 4 * (k / 16)))
                    m_sns[k] = wr_data[2*(k%16) +: 2];
            end
        end
    end

    // compare on every clock, away from the active edge (R13 with the current phase)
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (slot_req !== mreq()) begin
                n_fail++;
                $display("FAIL R13 (%s) slot_req act=%h exp=%h", phase, slot_req, mreq());
            end
            if (rd_chk) begin
                rd_chk = 0;
                n_chk++;
                if (rd_data !== m_rd) begin
                    n_fail++;
                    $display("FAIL %s rd_data act=%h exp=%h", phase, rd_data, m_rd);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic gp(input int idx, input logic v);
        @(negedge clk);
        gpio[idx] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired in phase %s act=running exp=finished", phase);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values of every register
        phase = "R1";
        rd(8'h20); rd(8'h24); rd(8'h28);
        for (int i = 0; i < 8; i++) rd(8'(8'h30 + 4 * i));

        // R2: select register layout and read back
        phase = "R2";
        wr(8'h30, 32'h8382_8180);
        wr(8'h4C, 32'h7F05_0A1F);
        rd(8'h30); rd(8'h4C); rd(8'h44);
        wr(8'h4C, 32'h0);

        // R3: sense register layout and read back
        phase = "R3";
        wr(8'h24, 32'hE4E4_E4E4);
        wr(8'h28, 32'h1B1B_1B1B);
        rd(8'h24); rd(8'h28);
        wr(8'h24, 32'h0);
        wr(8'h28, 32'h0);
        idle(3);

        // R4: rising edge on slot 0 (source 0) is sticky
        phase = "R4";
        gp(0, 1'b1); idle(3);
        gp(0, 1'b0); idle(3);
        rd(8'h20);

        // R8: write-zero clear, ones preserve, event beats clear
        phase = "R8";
        gp(1, 1'b1); idle(2);
        wr(8'h20, 32'hFFFF_FFFE);
        rd(8'h20);
        @(negedge clk);
        gpio[0] = 1'b1; wr_en = 1'b1; addr = 8'h20; wr_data = 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        rd(8'h20);
        gp(0, 1'b0);
        wr(8'h20, 32'h0);
        gp(1, 1'b0);
        rd(8'h20);

        // R5: falling edge on slot 2 (sense code 1 in bits 5:4)
        phase = "R5";
        wr(8'h24, 32'h0000_0010);
        gp(2, 1'b1); idle(2);
        gp(2, 1'b0); idle(2);
        gp(2, 1'b1); idle(2);
        rd(8'h20);

        // R6: level high on slot 3 (code 2 in bits 7:6)
        phase = "R6";
        wr(8'h24, 32'h0000_0090);
        gp(3, 1'b1); idle(3);
        rd(8'h20);

        // R12: clear during active level does not stick
        phase = "R12";
        wr(8'h20, 32'hFFFF_FFF7);
        rd(8'h20);
        gp(3, 1'b0); idle(2);
        rd(8'h20);

        // R7: level low on slot 16 (select 0x40 byte 0, sense 0x28 bits 1:0 = 3)
        phase = "R7";
        wr(8'h40, 32'h0000_0085);
        wr(8'h28, 32'h0000_0003);
        idle(3);
        gp(5, 1'b1); idle(2);
        gp(5, 1'b0); idle(2);
        rd(8'h20);

        // R9: disabled slot 0 stays quiet
        phase = "R9";
        wr(8'h20, 32'h0);
        wr(8'h30, 32'h8382_8100);
        gp(0, 1'b1); idle(2);
        gp(0, 1'b0); idle(2);
        rd(8'h20);

        // R10: source 0x70 is beyond the 100 inputs and reads low
        phase = "R10";
        wr(8'h4C, 32'hF000_0000);
        wr(8'h28, 32'h8000_0003);
        @(negedge clk); gpio = '1;
        idle(3);
        rd(8'h20);
        wr(8'h28, 32'hC000_0003);
        idle(3);
        rd(8'h20);
        @(negedge clk); gpio = '0;
        wr(8'h4C, 32'h0);
        wr(8'h28, 32'h0);
        wr(8'h40, 32'h0);
        wr(8'h24, 32'h0);
        wr(8'h20, 32'h0);

        // R11: source, enable and sense changes make no event
        phase = "R11";
        gp(7, 1'b1);
        wr(8'h30, 32'h8382_8700);
        idle(3);
        rd(8'h20);
        gp(7, 1'b0); idle(1);
        gp(7, 1'b1); idle(2);
        rd(8'h20);
        wr(8'h20, 32'h0);
        gp(9, 1'b1);
        wr(8'h30, 32'h8389_8700);
        idle(3);
        rd(8'h20);
        gp(7, 1'b0);
        wr(8'h24, 32'h0000_0004);
        idle(3);
        rd(8'h20);
        wr(8'h30, 32'h8389_8100);
        gp(1, 1'b1); idle(1);
        gp(1, 1'b0); idle(3);
        rd(8'h20);

        // R13: request equals enable AND status
        phase = "R13";
        wr(8'h30, 32'h0389_8100);
        idle(2);
        rd(8'h20);
        idle(5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule